// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A register-mapped general-purpose I/O bank of 31 pins behind a simple 32-bit read/write bus. Software holds an output value, can force individual output bits high or low through two atomic alias addresses without a read-modify-write, and chooses per pin whether the pad is pushed or only pulled low (open-drain). Pad inputs are resynchronised into the clock domain and read back through an input register.

Each pin has its own configuration word that picks one of several trigger modes (rising, falling or either edge, low or high level). Detected events land in a status register. Edge events are sticky until software writes 1 to the bit. Level events follow the pad level. Two combined outputs summarise the status: an interrupt line for pins whose interrupt-enable field is non-zero, and a wake request for pins whose wake bit is set.

Top module: `gpio_irq_bank`

Register offsets (byte addresses, word aligned): 0x00 output value, 0x04 set alias, 0x08 clear alias, 0x0C output enable, 0x10 synchronised input (read only), 0x14 event status (write 1 to clear), 0x80 + 4*n configuration of pin n. Bit n of each 31-bit register belongs to pin n; bit 31 reads 0.

## Requirements
- R1: After reset the output, output-enable, status and all configuration registers read 0, pad_oe is all zero, and irq and wake are 0.
- R2: A write to 0x04 drives each output bit whose write-data bit is 1 to 1 and leaves the others unchanged. A write to 0x00 loads the output register directly.
- R3: A write to 0x08 drives each output bit whose write-data bit is 1 to 0 and leaves the others unchanged.
- R4: In push-pull mode (configuration bit 2 = 0) pad_out[n] equals output bit n and pad_oe[n] equals output-enable bit n.
- R5: In open-drain mode (configuration bit 2 = 1) pad_out[n] is 0 and pad_oe[n] is 1 only when output-enable bit n is 1 and output bit n is 0.
- R6: Input register bit n shows pad_in[n] two clock edges after it changes, and not one edge after.
- R7: Trigger field bits 9:7 = 1 (rising), 2 (falling) or 3 (either) set status bit n on that transition; the bit stays set until a 1 is written to it at 0x14.
- R8: Trigger codes 4 (low level) and 5 (high level) make status bit n follow the matching pad level; writing 1 at 0x14 while the level persists leaves it set.
- R9: Trigger codes 0, 6 and 7 never set a status bit.
- R10: irq is 1 exactly when some status bit is set whose pin has a non-zero interrupt-enable field (configuration bits 17:13).
- R11: wake is 1 exactly when some status bit is set whose pin has its wake bit (configuration bit 10) set.
- R12: When an edge event and a write-1-to-clear of the same status bit take effect on the same clock edge, the bit ends set.
- R13: A configuration word reads back only bits 2, 9:7, 10 and 17:13 (other bits 0); addresses outside the map read 0 and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt |
| wake | output | 1 | Combined wake request |

## Verification
The one same-cycle overlap this block has is an edge event on a pin arriving at the status register on the very clock edge where software writes 1 to clear that bit. The bench provokes it by changing the pad in either-edge mode and placing the clear write exactly three clock edges later, the edge on which the synchronised event reaches status, and expects the bit to remain set; a clear issued one edge later on a quiet pin is the control and must leave it clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    TRG_OFF  = 3'd0,
    TRG_RISE = 3'd1,
    TRG_FALL = 3'd2,
    TRG_BOTH = 3'd3,
    TRG_LOW  = 3'd4,
    TRG_HIGH = 3'd5,
    TRG_RSV6 = 3'd6,
    TRG_RSV7 = 3'd7
  } trig_e;

  typedef struct packed {
    logic [4:0] int_en;
    logic       wake_en;
    trig_e      trig;
    logic       open_drain;
  } pin_cfg_t;

  // field positions inside a configuration word
  localparam int CFG_OD_BIT   = 2;
  localparam int CFG_TRIG_LSB = 7;
  localparam int CFG_WAKE_BIT = 10;
  localparam int CFG_IEN_LSB  = 13;

  // byte offsets
  localparam logic [7:0] A_OUT  = 8'h00;
  localparam logic [7:0] A_SET  = 8'h04;
  localparam logic [7:0] A_CLR  = 8'h08;
  localparam logic [7:0] A_OE   = 8'h0C;
  localparam logic [7:0] A_IN   = 8'h10;
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_CFG0 = 8'h80;

  function automatic pin_cfg_t word_to_cfg(input logic [31:0] w);
    pin_cfg_t c;
    c.open_drain = w[CFG_OD_BIT];
    c.trig       = trig_e'(w[CFG_TRIG_LSB +: 3]);
    c.wake_en    = w[CFG_WAKE_BIT];
    c.int_en     = w[CFG_IEN_LSB +: 5];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[CFG_OD_BIT]         = c.open_drain;
    w[CFG_TRIG_LSB +: 3]  = c.trig;
    w[CFG_WAKE_BIT]       = c.wake_en;
    w[CFG_IEN_LSB +: 5]   = c.int_en;
    return w;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = d;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
(
  input  trig_e trig,
  input  logic  cur,
  input  logic  prev,
  output logic  edge_evt,
  output logic  edge_mode,
  output logic  level_mode,
  output logic  level_cond
);

  always_comb begin
    edge_evt   = 1'b0;
    edge_mode  = 1'b0;
    level_mode = 1'b0;
    level_cond = 1'b0;
    unique case (trig)
      TRG_RISE: begin edge_mode = 1'b1; edge_evt = cur & ~prev; end
      TRG_FALL: begin edge_mode = 1'b1; edge_evt = ~cur & prev; end
      TRG_BOTH: begin edge_mode = 1'b1; edge_evt = cur ^ prev;  end
      TRG_LOW:  begin level_mode = 1'b1; level_cond = ~cur;     end
      TRG_HIGH: begin level_mode = 1'b1; level_cond = cur;      end
      default:  ; // off and reserved codes raise nothing
    endcase
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive (
  input  logic out_bit,
  input  logic oe_bit,
  input  logic open_drain,
  output logic pad_out,
  output logic pad_oe
);

  always_comb begin
    if (open_drain) begin
      pad_out = 1'b0;
      pad_oe  = oe_bit & ~out_bit;
    end else begin
      pad_out = out_bit;
      pad_oe  = oe_bit;
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 31,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq,
  output logic              wake
);

  localparam int IDX_W = $clog2(NPINS);

  // ---------------- address decode ----------------
  logic              wr;
  logic              hit_out, hit_set, hit_clr, hit_oe, hit_in, hit_stat, hit_cfg;
  logic [ADDR_W-1:0] cfg_off;
  logic [IDX_W-1:0]  cfg_idx;

  assign wr       = bus_sel & bus_we;
  assign hit_out  = (bus_addr == ADDR_W'(A_OUT));
  assign hit_set  = (bus_addr == ADDR_W'(A_SET));
  assign hit_clr  = (bus_addr == ADDR_W'(A_CLR));
  assign hit_oe   = (bus_addr == ADDR_W'(A_OE));
  assign hit_in   = (bus_addr == ADDR_W'(A_IN));
  assign hit_stat = (bus_addr == ADDR_W'(A_STAT));
  assign cfg_off  = bus_addr - ADDR_W'(A_CFG0);
  assign cfg_idx  = cfg_off[IDX_W+1:2];
  assign hit_cfg  = (bus_addr >= ADDR_W'(A_CFG0)) && (cfg_off[1:0] == 2'b00) &&
                    (int'(cfg_off >> 2) < NPINS);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // ---------------- state ----------------
  logic [NPINS-1:0] out_q, out_d, oe_q, oe_d, stat_q, stat_d;
  logic             out_en, oe_en;
  pin_cfg_t         cfg_q [NPINS];
  pin_cfg_t         cfg_d;
  logic [NPINS-1:0] cfg_en;

  logic [NPINS-1:0] sync_q, prev_q;
  logic [NPINS-1:0] edge_evt, edge_mode_v, level_mode_v, level_cond_v;
  logic [NPINS-1:0] ien_any, wake_v, od_v, stat_clr;

  // output and enable next state
  always_comb begin
    out_en = wr & (hit_out | hit_set | hit_clr);
    out_d  = out_q;
    if (hit_out)      out_d = bus_wdata[NPINS-1:0];
    else if (hit_set) out_d = out_q | bus_wdata[NPINS-1:0];
    else if (hit_clr) out_d = out_q & ~bus_wdata[NPINS-1:0];
    oe_en  = wr & hit_oe;
    oe_d   = bus_wdata[NPINS-1:0];
    cfg_d  = word_to_cfg(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      if (out_en) out_q <= out_d;
      if (oe_en)  oe_q  <= oe_d;
    end
  end

  // ---------------- input path ----------------
  gpio_in_sync #(.W(NPINS)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .sync_q(sync_q),
    .prev_q(prev_q)
  );

  assign stat_clr = (wr & hit_stat) ? bus_wdata[NPINS-1:0] : '0;

  // ---------------- per pin ----------------
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    assign cfg_en[n] = wr & hit_cfg & (cfg_idx == IDX_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[n] <= '0;
      else if (cfg_en[n]) cfg_q[n] <= cfg_d;
    end

    gpio_evt_detect i_det (
      .trig      (cfg_q[n].trig),
      .cur       (sync_q[n]),
      .prev      (prev_q[n]),
      .edge_evt  (edge_evt[n]),
      .edge_mode (edge_mode_v[n]),
      .level_mode(level_mode_v[n]),
      .level_cond(level_cond_v[n])
    );

    gpio_pad_drive i_drv (
      .out_bit   (out_q[n]),
      .oe_bit    (oe_q[n]),
      .open_drain(cfg_q[n].open_drain),
      .pad_out   (pad_out[n]),
      .pad_oe    (pad_oe[n])
    );

    assign ien_any[n] = |cfg_q[n].int_en;
    assign wake_v[n]  = cfg_q[n].wake_en;
    assign od_v[n]    = cfg_q[n].open_drain;

    // level pins follow the pad; others are sticky with set over clear
    assign stat_d[n] = level_mode_v[n] ? level_cond_v[n]
                                       : ((stat_q[n] & ~stat_clr[n]) | edge_evt[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign irq  = |(stat_q & ien_any);
  assign wake = |(stat_q & wake_v);

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (hit_out | hit_set | hit_clr) bus_rdata = DW'(out_q);
      else if (hit_oe)                 bus_rdata = DW'(oe_q);
      else if (hit_in)                 bus_rdata = DW'(sync_q);
      else if (hit_stat)               bus_rdata = DW'(stat_q);
      else if (hit_cfg)                bus_rdata = DW'(cfg_to_word(cfg_q[cfg_idx]));
    end
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 31,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  in_q,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  edge_evt,
  input logic [NPINS-1:0]  edge_mode,
  input logic [NPINS-1:0]  od_v,
  input logic [NPINS-1:0]  pad_out,
  input logic              irq
);

  logic [1:0]       cyc_q;
  logic             wr_set, wr_clr, wr_stat, wr_cfg;
  logic [NPINS-1:0] wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  assign wbits   = bus_wdata[NPINS-1:0];
  assign wr_set  = bus_sel & bus_we & (bus_addr == ADDR_W'(A_SET));
  assign wr_clr  = bus_sel & bus_we & (bus_addr == ADDR_W'(A_CLR));
  assign wr_stat = bus_sel & bus_we & (bus_addr == ADDR_W'(A_STAT));
  assign wr_cfg  = bus_sel & bus_we & (bus_addr >= ADDR_W'(A_CFG0));

  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (((out_q & $past(wbits)) == $past(wbits)) &&
                ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits)))));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (((out_q & $past(wbits)) == '0) &&
                ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits)))));

  p_od_no_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_v) == '0);

  p_sync_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3) |-> (in_q == $past(pad_in, 2)));

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));

  for (genvar n = 0; n < NPINS; n++) begin : g_p
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[n] && stat_q[n] && !(wr_stat && wbits[n]) && !wr_cfg) |=> stat_q[n]);

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[n] && edge_evt[n] && !wr_cfg) |=> stat_q[n]);
  end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DW(DW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pad_in   (pad_in),
  .out_q    (out_q),
  .in_q     (sync_q),
  .stat_q   (stat_q),
  .edge_evt (edge_evt),
  .edge_mode(edge_mode_v),
  .od_v     (od_v),
  .pad_out  (pad_out),
  .irq      (irq)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

  localparam int NPINS = 31;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel, bus_we;
  logic [7:0]        bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NPINS-1:0]  pad_in, pad_out, pad_oe;
  logic              irq, wake;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .wake(wake)
  );

  // {trigger code, pad before, pad after, expected status/irq}
  localparam logic [5:0] VEC [0:12] = '{
    {3'd1, 1'b0, 1'b1, 1'b1}, {3'd1, 1'b1, 1'b0, 1'b0},
    {3'd2, 1'b1, 1'b0, 1'b1}, {3'd2, 1'b0, 1'b1, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b1}, {3'd3, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b1, 1'b0, 1'b1}, {3'd4, 1'b0, 1'b1, 1'b0},
    {3'd5, 1'b0, 1'b1, 1'b1}, {3'd5, 1'b1, 1'b0, 1'b0},
    {3'd0, 1'b0, 1'b1, 1'b0}, {3'd6, 1'b0, 1'b1, 1'b0},
    {3'd7, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] cfga(input int n);
    return 8'h80 + 8'(4 * n);
  endfunction

  function automatic logic [31:0] cfgw(input logic [2:0] trig, input bit od,
                                       input bit wk, input logic [4:0] ien);
    return (32'(od) << 2) | (32'(trig) << 7) | (32'(wk) << 10) | (32'(ien) << 13);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk("R1 out", d, 32'h0);
    rd(8'h0C, d); chk("R1 oe", d, 32'h0);
    rd(8'h14, d); chk("R1 status", d, 32'h0);
    rd(cfga(0), d); chk("R1 cfg0", d, 32'h0);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 irq/wake", {30'b0, irq, wake}, 32'h0);

    // R2 / R3 output aliases
    wr(8'h00, 32'h0000_00F0);
    wr(8'h04, 32'h0F0F_0000);
    rd(8'h00, d); chk("R2 set alias", d, 32'h0F0F_00F0);
    wr(8'h08, 32'h0000_00F0);
    rd(8'h00, d); chk("R3 clear alias", d, 32'h0F0F_0000);

    // R4 push-pull
    wr(8'h0C, 32'h7FFF_FFFF);
    chk("R4 pad_out", 32'(pad_out), 32'h0F0F_0000);
    chk("R4 pad_oe", 32'(pad_oe), 32'h7FFF_FFFF);

    // R5 open-drain on pin 16
    wr(cfga(16), cfgw(3'd0, 1'b1, 1'b0, 5'd0));
    chk("R5 od released", {30'b0, pad_oe[16], pad_out[16]}, 32'h0);
    chk("R5 pin17 still push-pull", {30'b0, pad_oe[17], pad_out[17]}, 32'h3);
    wr(8'h08, 32'h0001_0000);
    chk("R5 od drives low", {30'b0, pad_oe[16], pad_out[16]}, 32'h2);
    wr(8'h0C, 32'h7FFE_FFFF);
    chk("R5 od oe off", {30'b0, pad_oe[16], pad_out[16]}, 32'h0);

    // R13 readback masking and unmapped space
    wr(cfga(5), 32'hFFFF_FFFF);
    rd(cfga(5), d); chk("R13 cfg fields", d, 32'h0003_E784);
    wr(cfga(5), 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R13 out bit31", d, 32'h7FFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R13 unmapped", d, 32'h0);
    rd(cfga(31), d); chk("R13 no pin31 cfg", d, 32'h0);
    rd(8'h0C, d); chk("R13 unmapped write ignored", d, 32'h7FFE_FFFF);

    // R6 input synchroniser latency
    pad_in = 31'h1234_5678;
    @(negedge clk);
    rd(8'h10, d); chk("R6 one edge", d, 32'h0);
    @(negedge clk);
    rd(8'h10, d); chk("R6 two edges", d, 32'h1234_5678);
    pad_in = '0;
    repeat (4) @(negedge clk);

    // R7 R8 R9 R10 trigger table on pin 0
    for (int i = 0; i < 13; i++) begin
      wr(cfga(0), cfgw(VEC[i][5:3], 1'b0, 1'b0, 5'd1));
      pad_in[0] = VEC[i][2];
      repeat (5) @(negedge clk);
      wr(8'h14, 32'h1);
      pad_in[0] = VEC[i][1];
      repeat (5) @(negedge clk);
      rd(8'h14, d);
      chk($sformatf("R7/R8/R9 vec%0d status", i), {31'b0, d[0]}, {31'b0, VEC[i][0]});
      chk($sformatf("R10 vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end

    // R8 clear ignored while level present
    wr(cfga(0), cfgw(3'd4, 1'b0, 1'b0, 5'd1));
    pad_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    wr(8'h14, 32'h1);
    rd(8'h14, d); chk("R8 level survives clear", {31'b0, d[0]}, 32'h1);
    wr(cfga(0), cfgw(3'd0, 1'b0, 1'b0, 5'd1));
    wr(8'h14, 32'h1);
    rd(8'h14, d); chk("R9 off mode cleared", d, 32'h0);

    // R11 wake without interrupt enable, pin 3
    wr(cfga(3), cfgw(3'd1, 1'b0, 1'b1, 5'd0));
    pad_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 wake set, irq clear", {30'b0, wake, irq}, 32'h2);
    wr(8'h14, 32'h8);
    chk("R11 wake after clear", {31'b0, wake}, 32'h0);

    // R12 event and clear on the same edge, pin 0 either-edge
    wr(cfga(0), cfgw(3'd3, 1'b0, 1'b0, 5'd1));
    pad_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(8'h14, d); chk("R12 precondition", {31'b0, d[0]}, 32'h1);
    pad_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h14, 32'h1);          // takes effect on third edge after pad change
    rd(8'h14, d); chk("R12 set beats clear", {31'b0, d[0]}, 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h14, d); chk("R12 quiet clear", {31'b0, d[0]}, 32'h0);
    chk("R10 irq drops", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule